// File: doc/BRIEF.md
# Four-Way Sync Pulse Delay and Stretch Aligner

This block takes one asynchronous sync pulse from outside the chip and turns it into four trigger pulses, one per output channel. Every channel waits its own programmed number of clock cycles after the sync edge and then drives a pulse whose length is its own programmed width. Since each channel's downstream path has a different latency, calibrating the per-channel delays makes all four downstream events happen at the same moment. The width setting makes each pulse as long as its driver needs, whatever the width of the incoming sync.

A processor sets the delays and widths through a plain write port. Written values sit in a staging bank. A channel copies them in only when it accepts a new sync edge, so a pulse that has already started is never changed. A sync edge that reaches a channel while that channel is still waiting or pulsing has no effect on it and sets that channel's sticky overlap flag.

Each channel is a three-state machine. The states are `CH_IDLE`, `CH_DELAY` and `CH_PULSE`. The transitions are:
- idle→delay: an edge arrives, width is nonzero and delay is nonzero.
- idle→pulse: an edge arrives, width is nonzero and delay is zero.
- idle→idle: an edge arrives and width is zero.
- delay→pulse: the delay count runs out.
- pulse→idle: the width count runs out.

Top module: `sync_fanout_aligner`

## Requirements
- R1: While reset is held and right after it is released, every `trig_out` bit and every `overlap` bit is 0. All staged delays and widths are 0.
- R2: `sync_in` passes through two synchronizing flops, and only a rising edge is detected. With accepted delay D and width W, a channel's trigger first reads high after the (D+3)-th rising clock edge, counting as edge 1 the first edge that samples `sync_in` high.
- R3: An accepted trigger stays high for exactly W clock cycles and then returns low.
- R4: A delay of 0 makes the trigger go high right after the 3rd edge, which is the cycle after edge detection.
- R5: A width of 0 disables the channel. A sync edge then produces no pulse and sets no overlap flag.
- R6: A sync edge that arrives while a channel is in its delay or pulse state does not restart or lengthen that channel's pulse. It sets that channel's `overlap` bit, which stays set.
- R7: A write to address 8 clears each `overlap` bit whose matching `wr_data` bit (bit 0 to bit 3) is 1. If a new overlap is detected in the same cycle, the bit stays set.
- R8: A write changes only the staged value. A channel samples the staged value at the edge it accepts, so a write does not alter a delay or pulse already in progress.
- R9: Register addresses are {0, channel[1:0], sel}. sel=0 selects the 16-bit delay and sel=1 selects the 16-bit width, both counted in clock cycles. Each channel times independently.
- R10: Holding `sync_in` high produces only one edge. No new edge is seen until `sync_in` has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | External sync pulse, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| trig_out | output | 4 | Per-channel stretched, delayed trigger |
| overlap | output | 4 | Per-channel sticky overlap flag |

## Verification
A trigger first reads high after the (D+3)-th clock edge following the edge that first samples sync high. It falls after the (D+W+3)-th edge. An overlap flag sets after the 3rd edge, and a clear takes effect one edge after the write. A staged write becomes visible only at the next accepted edge. The bench keeps a cycle-indexed model of each channel's start and end edge and of the synchronizer pipeline. It drives inputs on falling edges and compares both output buses against that model on every falling edge. A result is therefore always sampled half a cycle after the edge that is due to change it. Directed phases cover the zero-delay, zero-width, held-sync, overlap and mid-pulse-write cases, and a seeded random phase then mixes all of them.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DELAY = 2'd1,
        CH_PULSE = 2'd2
    } ch_state_e;
endpackage

// File: rtl/sfa_sync_edge.sv
module sfa_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    always_comb rise = sync_q & ~last_q;

    // R10
    single_cycle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sfa_cfg_bank.sv
module sfa_cfg_bank #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NCH)+1:0]   wr_addr,
    input  logic [CW-1:0]            wr_data,
    output logic [NCH-1:0][CW-1:0]   stage_delay,
    output logic [NCH-1:0][CW-1:0]   stage_width,
    output logic [NCH-1:0]           flag_clr
);
    localparam int CHB = $clog2(NCH);
    localparam int AW  = CHB + 2;
    localparam logic [AW-1:0] CLR_ADDR = AW'(1) << (AW - 1);

    for (genvar c = 0; c < NCH; c++) begin : g_reg
        localparam logic [AW-1:0] D_ADDR = {1'b0, CHB'(c), 1'b0};
        localparam logic [AW-1:0] W_ADDR = {1'b0, CHB'(c), 1'b1};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_delay[c] <= '0;
                stage_width[c] <= '0;
            end else if (wr_en) begin
                if (wr_addr == D_ADDR) stage_delay[c] <= wr_data;
                if (wr_addr == W_ADDR) stage_width[c] <= wr_data;
            end
        end

        always_comb flag_clr[c] = wr_en && (wr_addr == CLR_ADDR) && wr_data[c];
    end
endmodule

// File: rtl/sfa_chan_timer.sv
module sfa_chan_timer
    import sfa_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] stage_delay,
    input  logic [CW-1:0] stage_width,
    input  logic          flag_clr,
    output logic          trig,
    output logic          ovl
);
    ch_state_e     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [CW-1:0] act_w, act_w_n;
    logic          ovl_set;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        act_w_n = act_w;
        ovl_set = 1'b0;
        unique case (state)
            CH_IDLE: begin
                if (start && stage_width != '0) begin
                    act_w_n = stage_width;
                    if (stage_delay == '0) begin
                        state_n = CH_PULSE;
                        cnt_n   = stage_width - CW'(1);
                    end else begin
                        state_n = CH_DELAY;
                        cnt_n   = stage_delay - CW'(1);
                    end
                end
            end
            CH_DELAY: begin
                ovl_set = start;
                if (cnt == '0) begin
                    state_n = CH_PULSE;
                    cnt_n   = act_w - CW'(1);
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            CH_PULSE: begin
                ovl_set = start;
                if (cnt == '0) state_n = CH_IDLE;
                else           cnt_n   = cnt - CW'(1);
            end
            default: state_n = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            cnt   <= '0;
            act_w <= '0;
            ovl   <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            act_w <= act_w_n;
            if (ovl_set)       ovl <= 1'b1;
            else if (flag_clr) ovl <= 1'b0;
        end
    end

    always_comb trig = (state == CH_PULSE);

    // R6
    busy_edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != CH_IDLE) |=> ovl);
    // R5
    zero_width_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == CH_IDLE && stage_width == '0) |=> !trig);
    // R4
    zero_delay_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == CH_IDLE && stage_width != '0 && stage_delay == '0) |=> trig);
    // R8
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_IDLE) |=> (state == CH_IDLE || $stable(act_w)));
    // R3
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && cnt == '0) |=> !trig);
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(start && state != CH_IDLE)) |=> !ovl);
endmodule

// File: rtl/sync_fanout_aligner.sv
module sync_fanout_aligner #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_in,
    input  logic                   wr_en,
    input  logic [$clog2(NCH)+1:0] wr_addr,
    input  logic [CW-1:0]          wr_data,
    output logic [NCH-1:0]         trig_out,
    output logic [NCH-1:0]         overlap
);
    logic                   sync_rise;
    logic [NCH-1:0][CW-1:0] stage_delay;
    logic [NCH-1:0][CW-1:0] stage_width;
    logic [NCH-1:0]         flag_clr;

    sfa_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .rise     (sync_rise)
    );

    sfa_cfg_bank #(.NCH(NCH), .CW(CW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .stage_delay (stage_delay),
        .stage_width (stage_width),
        .flag_clr    (flag_clr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sfa_chan_timer #(.CW(CW)) u_tmr (
            .clk         (clk),
            .rst_n       (rst_n),
            .start       (sync_rise),
            .stage_delay (stage_delay[c]),
            .stage_width (stage_width[c]),
            .flag_clr    (flag_clr[c]),
            .trig        (trig_out[c]),
            .ovl         (overlap[c])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (trig_out == '0));
endmodule

// File: tb/tb_sync_fanout_aligner.sv
`timescale 1ns/1ps
module tb_sync_fanout_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  trig_out, overlap;

    int errors = 0;
    int checks = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model state
    int          cyc = 0;
    int          st_t [4];
    int          en_t [4];
    logic [15:0] md [4];
    logic [15:0] mw [4];
    bit          mf [4];
    bit          ms1, ms2, ms3;

    always #4 clk = ~clk;

    sync_fanout_aligner dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .trig_out(trig_out), .overlap(overlap)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; ms1 = 0; ms2 = 0; ms3 = 0;
            for (int c = 0; c < 4; c++) begin
                st_t[c] = 0; en_t[c] = 0; md[c] = 0; mw[c] = 0; mf[c] = 0;
            end
        end else begin
            bit e;
            bit setf;
            cyc = cyc + 1;
            e = ms2 && !ms3;
            for (int c = 0; c < 4; c++) begin
                setf = 0;
                if (e) begin
                    if (cyc <= en_t[c]) setf = 1;
                    else if (mw[c] != 0) begin
                        st_t[c] = cyc + int'(md[c]);
                        en_t[c] = cyc + int'(md[c]) + int'(mw[c]);
                    end
                end
                if (setf) mf[c] = 1;
                else if (wr_en && wr_addr == 4'd8 && wr_data[c]) mf[c] = 0;
            end
            if (wr_en && !wr_addr[3]) begin
                if (wr_addr[0]) mw[wr_addr[2:1]] = wr_data;
                else            md[wr_addr[2:1]] = wr_data;
            end
            ms3 = ms2; ms2 = ms1; ms1 = sync_in;
        end
    end

    function automatic logic [3:0] exp_trig();
        logic [3:0] r;
        for (int c = 0; c < 4; c++) r[c] = (st_t[c] <= cyc) && (cyc < en_t[c]);
        return r;
    endfunction

    function automatic logic [3:0] exp_flag();
        logic [3:0] r;
        for (int c = 0; c < 4; c++) r[c] = mf[c];
        return r;
    endfunction

    task automatic check4(input string what, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d got %b expected %b", tag, what, cyc, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            check4("trig_out", trig_out, exp_trig());
            check4("overlap", overlap, exp_flag());
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] ch, input logic [15:0] d, input logic [15:0] w);
        wr({1'b0, ch, 1'b0}, d);
        wr({1'b0, ch, 1'b1}, w);
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk);
        sync_in = 1'b1;
        step(hi);
        sync_in = 1'b0;
        step(lo);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R2 watchdog got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        tag = "R1";
        step(3);
        check4("trig_out in reset", trig_out, 4'b0);
        check4("overlap in reset", overlap, 4'b0);
        @(negedge clk) rst_n = 1'b1;
        chk_on = 1'b1;
        step(2);

        tag = "R9";   // distinct settings per channel
        cfg(2'd0, 16'd0, 16'd3);
        cfg(2'd1, 16'd5, 16'd2);
        cfg(2'd2, 16'd1, 16'd1);
        cfg(2'd3, 16'd9, 16'd4);
        tag = "R2";
        pulse(2, 30);
        tag = "R4";   // zero delay on every channel
        for (int c = 0; c < 4; c++) cfg(2'(c), 16'd0, 16'(c + 1));
        pulse(1, 20);
        tag = "R5";   // width zero on channels 1 and 3
        cfg(2'd1, 16'd2, 16'd0);
        cfg(2'd3, 16'd0, 16'd0);
        pulse(3, 20);
        tag = "R10";  // long hold must give one edge
        cfg(2'd0, 16'd3, 16'd2);
        pulse(40, 20);
        tag = "R6";   // second edge while channel 2 busy
        cfg(2'd2, 16'd20, 16'd10);
        pulse(1, 7);
        pulse(1, 40);
        tag = "R7";
        wr(4'd8, 16'h0004);
        step(3);
        tag = "R8";   // change staged values mid-pulse
        cfg(2'd0, 16'd2, 16'd20);
        pulse(1, 8);
        cfg(2'd0, 16'd0, 16'd1);
        step(25);
        pulse(1, 10);
        wr(4'd8, 16'h000F);

        tag = "R3";   // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (($urandom % 8) == 0) sync_in = ~sync_in;
            case ($urandom % 12)
                0: begin
                    wr_en = 1'b1; wr_addr = {1'b0, 2'($urandom % 4), 1'b0};
                    wr_data = 16'($urandom % 16);
                end
                1: begin
                    wr_en = 1'b1; wr_addr = {1'b0, 2'($urandom % 4), 1'b1};
                    wr_data = 16'($urandom % 13);
                end
                2: if (($urandom % 4) == 0) begin
                    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 16'($urandom % 16);
                end
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0; sync_in = 1'b0;
        step(40);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule